// File: doc/BRIEF.md
# FSK Carrier Presence Qualifier

This block decides whether a usable frequency-shift-keyed carrier is present on a receive line. Its input is one digital pulse for each received waveform cycle whose amplitude passes an external level comparator. The pulse arrives asynchronously, so it is resynchronised and only its rising edges are used. A run of consecutive edges marks the carrier as present. The carrier stays present for as long as edges keep arriving within a fixed gap window. A separate gap timer advances on a slow clock enable of 460.8 kHz, so the default window of 1152 ticks is 2.5 ms.

A local transmit-idle input is high while the device is not transmitting. Whenever that input is low, the block clears all of its state, so the device never reports its own carrier. With the defaults, four edges are needed to assert. That takes about 3.3 ms for a 1200 Hz carrier and about 1.8 ms for a 2200 Hz carrier.

Top module: `fsk_carrier_qualifier`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `carrier_o` is 0 and the edge count is zero.
- R2: `carrier_o` rises only after `PULSE_RUN` (default 4) consecutive rising edges of the synchronised pulse. After `PULSE_RUN`-1 edges it is still 0. It rises three clock cycles after the input edge that completes the run.
- R3: A pulse that is held high for many cycles counts as exactly one edge. Only low-to-high transitions of `cmp_pulse_i` advance the count.
- R4: Once high, `carrier_o` stays high while each new edge arrives fewer than `GAP_TICKS` enabled ticks after the previous one.
- R5: If `GAP_TICKS` ticks of `tick_en` pass with no edge, `carrier_o` falls and the edge count returns to zero.
- R6: A gap timeout reached before the run is complete discards the partial count. A full new run of `PULSE_RUN` edges is then required.
- R7: After `carrier_o` falls, it rises again only after `PULSE_RUN` fresh consecutive edges.
- R8: When `tx_idle_i` is 0, `carrier_o` is 0 from the next cycle on. The edge count and the gap timer are cleared, and edges that arrive meanwhile are not counted. This also holds when the low level coincides with the edge that would complete a run.
- R9: The gap timer advances only in cycles where `tick_en` is 1. With `tick_en` held at 0, a present carrier never times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Gap-timer enable strobe (460.8 kHz rate) |
| cmp_pulse_i | input | 1 | Asynchronous comparator pulse, one per qualifying cycle |
| tx_idle_i | input | 1 | 1 = local transmitter off; 0 = transmitting, detection suppressed |
| carrier_o | output | 1 | Registered carrier-present flag |

## Verification
Transmit gating and run completion can fall in the same cycle. The bench provokes this by dropping `tx_idle_i` exactly in the cycle where the synchronised fourth edge is seen. It then checks that `carrier_o` never rises. It also checks that three further edges after the release still leave the carrier low, which shows that the count really was flushed. The other collision, an edge landing on the timeout tick, is resolved in the RTL as a drop followed by a count of one.

// File: rtl/cq_pkg.sv
package cq_pkg;
  typedef enum logic [1:0] {
    CQ_IDLE  = 2'd0,
    CQ_COUNT = 2'd1,
    CQ_LOCK  = 2'd2
  } cq_state_e;
endpackage

// File: rtl/cq_edge_sync.sv
module cq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  localparam int LEN = STAGES + 1;

  logic [LEN-1:0] sh;

  generate
    for (genvar i = 0; i < LEN; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sh[i] <= 1'b0;
          else     sh[i] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sh[i] <= 1'b0;
          else     sh[i] <= sh[i-1];
        end
      end
    end
  endgenerate

  // the last stage holds the previous synchronised level
  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/cq_gap_timer.sv
module cq_gap_timer #(
  parameter int GAP_TICKS = 1152
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  input  logic flush,
  input  logic tick_en,
  output logic expire
);
  localparam int TW = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1;
  localparam logic [TW-1:0] LAST = TW'(GAP_TICKS - 1);

  logic [TW-1:0] cnt;

  assign expire = run && !flush && tick_en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || flush || restart || !run) cnt <= '0;
    else if (tick_en)                    cnt <= expire ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/cq_pulse_counter.sv
module cq_pulse_counter #(
  parameter int PULSE_RUN = 4,
  localparam int CW = $clog2(PULSE_RUN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          restart,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          hit
);
  localparam logic [CW-1:0] FULL = CW'(PULSE_RUN);
  localparam logic [CW-1:0] ONE  = CW'(1);

  // completes a run only when no timeout discards it in the same cycle
  assign hit = inc && !restart && !flush && (cnt == FULL - ONE);

  always_ff @(posedge clk) begin
    if (rst || flush)        cnt <= '0;
    else if (restart)        cnt <= inc ? ONE : '0;
    else if (inc && cnt != FULL) cnt <= cnt + ONE;
  end
endmodule

// File: rtl/fsk_carrier_qualifier.sv
module fsk_carrier_qualifier
  import cq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_RUN   = 4,
  parameter int GAP_TICKS   = 1152
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic cmp_pulse_i,
  input  logic tx_idle_i,
  output logic carrier_o
);
  localparam int CW = $clog2(PULSE_RUN + 1);

  cq_state_e     state, state_nx;
  logic          rise_w, expire_w, hit_w, flush_w, run_w;
  logic [CW-1:0] cnt_w;
  logic          carrier_q;

  assign flush_w = !tx_idle_i;
  assign run_w   = (state != CQ_IDLE);

  cq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (cmp_pulse_i),
    .rise(rise_w)
  );

  cq_gap_timer #(.GAP_TICKS(GAP_TICKS)) u_gap (
    .clk    (clk),
    .rst    (rst),
    .run    (run_w),
    .restart(rise_w),
    .flush  (flush_w),
    .tick_en(tick_en),
    .expire (expire_w)
  );

  cq_pulse_counter #(.PULSE_RUN(PULSE_RUN)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .flush  (flush_w),
    .restart(expire_w),
    .inc    (rise_w),
    .cnt    (cnt_w),
    .hit    (hit_w)
  );

  always_comb begin
    state_nx = state;
    if (flush_w) begin
      state_nx = CQ_IDLE;
    end else begin
      case (state)
        CQ_IDLE:  if (rise_w) state_nx = CQ_COUNT;
        CQ_COUNT: begin
          if (expire_w)   state_nx = rise_w ? CQ_COUNT : CQ_IDLE;
          else if (hit_w) state_nx = CQ_LOCK;
        end
        CQ_LOCK:  if (expire_w) state_nx = rise_w ? CQ_COUNT : CQ_IDLE;
        default:  state_nx = CQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= CQ_IDLE;
      carrier_q <= 1'b0;
    end else begin
      state     <= state_nx;
      carrier_q <= (state_nx == CQ_LOCK);
    end
  end

  assign carrier_o = carrier_q;
endmodule

// File: rtl/cq_checker.sv
module cq_checker #(
  parameter int PULSE_RUN = 4,
  localparam int CW = $clog2(PULSE_RUN + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          tx_idle_i,
  input logic          carrier_o,
  input logic          rise_w,
  input logic          expire_w,
  input logic [CW-1:0] cnt_w
);
  localparam logic [CW-1:0] FULL = CW'(PULSE_RUN);

  // R1
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (!carrier_o && cnt_w == '0));
  // R2
  p_rise_after_run_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(carrier_o) |-> ($past(rise_w) && $past(cnt_w) == FULL - CW'(1)));
  p_count_bound_r2: assert property (@(posedge clk) disable iff (rst) cnt_w <= FULL);
  // R4
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (carrier_o && tx_idle_i && !expire_w) |=> carrier_o);
  // R5
  p_timeout_drop_r5: assert property (@(posedge clk) disable iff (rst)
    expire_w |=> (!carrier_o && cnt_w <= CW'(1)));
  // R8
  p_tx_gate_r8: assert property (@(posedge clk) disable iff (rst)
    !tx_idle_i |=> (!carrier_o && cnt_w == '0));
endmodule

bind fsk_carrier_qualifier cq_checker #(.PULSE_RUN(PULSE_RUN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tx_idle_i(tx_idle_i),
  .carrier_o(carrier_o),
  .rise_w   (rise_w),
  .expire_w (expire_w),
  .cnt_w    (cnt_w)
);

// File: tb/fsk_carrier_qualifier_test.sv
module fsk_carrier_qualifier_test;
  localparam int RUN = 4;
  localparam int GAP = 20;  // ticks; one tick every 4 clocks => 80 clocks

  typedef struct {
    bit    exp;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_raw = 1'b0;
  logic tick_on = 1'b1;
  logic tick_en;
  logic cmp_pulse_i = 1'b0;
  logic tx_idle_i = 1'b1;
  logic carrier_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  item_t q[$];

  assign tick_en = tick_raw & tick_on;

  always #4 clk = ~clk;

  fsk_carrier_qualifier #(.SYNC_STAGES(2), .PULSE_RUN(RUN), .GAP_TICKS(GAP)) uut (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .cmp_pulse_i(cmp_pulse_i),
    .tx_idle_i  (tx_idle_i),
    .carrier_o  (carrier_o)
  );

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      tick_raw = 1'b1;
      @(negedge clk);
      tick_raw = 1'b0;
    end
  end

  // monitor: pops expected items and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_run++;
        if (carrier_o !== it.exp) begin
          n_fail++;
          $display("FAIL %s: carrier_o=%0b expected %0b", it.tag, carrier_o, it.exp);
        end
      end
    end
  end

  task automatic expect_c(input bit v, input string tag);
    item_t it;
    it.exp = v;
    it.tag = tag;
    q.push_back(it);
    repeat (2) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int n, input int period, input int high);
    for (int i = 0; i < n; i++) begin
      cmp_pulse_i = 1'b1;
      repeat (high) @(negedge clk);
      cmp_pulse_i = 1'b0;
      repeat (period - high) @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: done=%0b expected %0b", done, 1'b1);
      summary();
    end
  end

  initial begin
    idle(4);
    expect_c(1'b0, "R1 during reset");
    rst = 1'b0;
    expect_c(1'b0, "R1 after reset");

    // R2: three edges are not enough, the fourth asserts
    pulses(3, 40, 20);
    expect_c(1'b0, "R2 three edges");
    pulses(1, 40, 20);
    expect_c(1'b1, "R2 fourth edge");

    // R4: gaps of 16 ticks keep the carrier
    pulses(6, 64, 10);
    expect_c(1'b1, "R4 gaps under window");

    // R5: silence drops it
    idle(120);
    expect_c(1'b0, "R5 gap timeout");

    // R7: one fresh edge after the drop is not enough
    pulses(1, 40, 20);
    expect_c(1'b0, "R7 single fresh edge");
    idle(200);

    // R3: a long-high pulse counts once
    pulses(1, 70, 60);
    pulses(2, 40, 20);
    expect_c(1'b0, "R3 long pulse counted once");
    pulses(1, 40, 20);
    expect_c(1'b1, "R3 fourth edge");

    // R6: timeout during counting discards the partial run
    idle(200);
    expect_c(1'b0, "R5 second drop");
    pulses(3, 40, 20);
    idle(120);
    pulses(1, 40, 20);
    expect_c(1'b0, "R6 partial run discarded");
    pulses(2, 40, 20);
    expect_c(1'b0, "R6 three fresh edges");
    pulses(1, 40, 20);
    expect_c(1'b1, "R6 four fresh edges");

    // R8: transmit gating
    tx_idle_i = 1'b0;
    idle(1);
    expect_c(1'b0, "R8 tx active clears");
    pulses(5, 40, 20);
    expect_c(1'b0, "R8 edges ignored while tx");
    tx_idle_i = 1'b1;
    pulses(3, 40, 20);
    expect_c(1'b0, "R8 count flushed");
    pulses(1, 40, 20);
    expect_c(1'b1, "R8 run after release");

    // R8: tx goes low in the very cycle the fourth edge is seen
    idle(200);
    pulses(3, 40, 20);
    cmp_pulse_i = 1'b1;
    idle(2);
    tx_idle_i = 1'b0;
    idle(1);
    expect_c(1'b0, "R8 same-cycle gate");
    cmp_pulse_i = 1'b0;
    idle(4);
    tx_idle_i = 1'b1;
    pulses(3, 40, 20);
    expect_c(1'b0, "R8 same-cycle flushed");
    pulses(1, 40, 20);
    expect_c(1'b1, "R8 same-cycle recovery");

    // R9: timer frozen without tick_en
    tick_on = 1'b0;
    idle(400);
    expect_c(1'b1, "R9 no ticks no timeout");
    tick_on = 1'b1;
    idle(200);
    expect_c(1'b0, "R9 ticks resume timeout");

    // R1: reset in operation
    pulses(4, 20, 10);
    expect_c(1'b1, "R2 fast carrier");
    rst = 1'b1;
    idle(2);
    expect_c(1'b0, "R1 mid-run reset");
    rst = 1'b0;
    expect_c(1'b0, "R1 stays low");

    idle(4);
    done = 1'b1;
    summary();
  end
endmodule